// File: doc/BRIEF.md
# Bus Hold and Backoff Release Arbiter

This block decides when a bus master hands its external bus to another master and when it takes it back. It watches an ordinary hold request, an active-low backoff input, a bus-lock indication and a busy flag from the bus sequencer. From these it drives a set of output-enable lines for the bus drivers, a hold-acknowledge, a one-clock restart request for a cycle cut short by backoff, gated ready strobes for the sequencer and a pending-request flag.

An ordinary hold is polite: it is acknowledged only once the sequencer reports no cycle, burst or locked sequence in flight. Backoff is forceful: the drivers are released on the next clock whatever is in progress, any ready arriving alongside it is discarded, no acknowledge is given, and the interrupted cycle is flagged so the sequencer can run it again from its start once backoff is lifted.

Top module: `bus_release_arb`

## Requirements
- R1: While reset is low, hold-acknowledge and restart are 0 and every output-enable bit is 1; reset acts without waiting for a clock edge.
- R2: Hold-acknowledge rises in the clock after an edge that samples the hold request high with the busy flag low and the lock indication low; while the busy flag is high at each edge it stays 0.
- R3: Hold-acknowledge never rises after an edge that samples the lock indication high.
- R4: Every output-enable bit is 0 in each clock where hold-acknowledge is 1; acknowledge drops in the clock after an edge that samples the hold request low, and the drivers are enabled again in that same clock unless backoff still applies.
- R5: All output-enable bits go to 0 in the clock after an edge that samples the backoff input low (0 = backoff active), without any hold-acknowledge.
- R6: The gated ready strobes are 0 whenever the backoff input is low; the burst-ready strobe is also 0 whenever the single ready input is low (both ready inputs active low, strobes active high).
- R7: Once floated by backoff, the output-enable bits stay 0 until an edge samples the backoff input high, and return to 1 in the next clock when no hold is acknowledged.
- R8: If the busy flag was high at the edge where backoff was first sampled, restart is 1 for exactly the one clock following the edge that samples backoff released; a backoff taken while idle gives no restart.
- R9: When hold and backoff overlap, the bus stays floated until both are released, and hold-acknowledge follows only the hold rules of R2 to R4.
- R10: The pending-request output is the OR of the internal need lines together with an outstanding interrupted cycle, whether or not the bus is currently owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| hold_req_i | input | 1 | Ordinary hold request from another master |
| boff_n_i | input | 1 | Backoff request, active low |
| lock_i | input | 1 | Locked sequence in progress |
| cyc_busy_i | input | 1 | Sequencer has a cycle or burst in flight |
| rdy_n_i | input | 1 | Single-transfer ready, active low |
| brdy_n_i | input | 1 | Burst ready, active low |
| need_i | input | NUM_REQ | Internal bus need lines |
| bus_oe_o | output | OE_GROUPS | Driver enables for the bus output groups |
| hold_ack_o | output | 1 | Hold acknowledge |
| restart_o | output | 1 | One-clock request to rerun the interrupted cycle |
| rdy_ok_o | output | 1 | Ready accepted, active high |
| brdy_ok_o | output | 1 | Burst ready accepted, active high |
| pend_req_o | output | 1 | Internal bus request pending |

## Verification
Two pairs of functions can land in one clock: a backoff arriving on the same edge as a ready, and a hold request overlapping a backoff window. The first is provoked by driving the backoff input low while the ready input is active during a busy cycle, judged by both gated strobes being 0 and a restart pulse following the release. The second is provoked by raising hold before, during and after backoff in several orders, judged by the drivers staying off until the last of the two is released while acknowledge tracks only the hold request.

// File: rtl/bha_pkg.sv
package bha_pkg;

   // Why the bus drivers are currently released
   typedef enum logic [1:0] {
      REL_NONE = 2'b00,
      REL_HOLD = 2'b01,
      REL_BOFF = 2'b10,
      REL_BOTH = 2'b11
   } rel_cause_e;

   function automatic rel_cause_e rel_cause(input logic ack, input logic boff);
      return rel_cause_e'({boff, ack});
   endfunction

   function automatic logic drivers_on(input rel_cause_e c);
      return (c == REL_NONE);
   endfunction

endpackage

// File: rtl/bha_hold_ctl.sv
module bha_hold_ctl (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic hold_req_i,
   input  logic cyc_busy_i,
   input  logic lock_i,
   output logic hold_ack_o
);
   logic ack_q;
   logic grant_ok;

   // A fresh grant needs an idle sequencer and no lock; an existing grant
   // lasts as long as the request does.
   assign grant_ok = ~cyc_busy_i & ~lock_i;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) ack_q <= 1'b0;
      else          ack_q <= hold_req_i & (ack_q | grant_ok);
   end

   assign hold_ack_o = ack_q;
endmodule

// File: rtl/bha_boff_ctl.sv
module bha_boff_ctl (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic boff_n_i,
   input  logic cyc_busy_i,
   output logic boff_q_o,
   output logic intr_q_o,
   output logic restart_o
);
   logic boff_q;
   logic intr_q;
   logic restart_q;
   logic boff_start;
   logic boff_end;

   assign boff_start = ~boff_n_i & ~boff_q;
   assign boff_end   =  boff_n_i &  boff_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         boff_q    <= 1'b0;
         intr_q    <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         boff_q    <= ~boff_n_i;
         restart_q <= boff_end & intr_q;
         if (boff_start && cyc_busy_i) intr_q <= 1'b1;
         else if (boff_end)            intr_q <= 1'b0;
      end
   end

   assign boff_q_o  = boff_q;
   assign intr_q_o  = intr_q;
   assign restart_o = restart_q;
endmodule

// File: rtl/bha_rdy_gate.sv
module bha_rdy_gate (
   input  logic boff_n_i,
   input  logic rdy_n_i,
   input  logic brdy_n_i,
   output logic rdy_ok_o,
   output logic brdy_ok_o
);
   // Backoff outranks both readies; single ready outranks burst ready.
   assign rdy_ok_o  = boff_n_i & ~rdy_n_i;
   assign brdy_ok_o = boff_n_i &  rdy_n_i & ~brdy_n_i;
endmodule

// File: rtl/bha_pend.sv
module bha_pend #(
   parameter int NUM_REQ  = 4,
   parameter bit PEND_REG = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic [NUM_REQ-1:0] need_i,
   input  logic               intr_i,
   output logic               pend_o
);
   logic pend_c;

   assign pend_c = (|need_i) | intr_i;

   generate
      if (PEND_REG) begin : g_reg
         logic pend_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) pend_q <= 1'b0;
            else          pend_q <= pend_c;
         end
         assign pend_o = pend_q;
      end else begin : g_comb
         assign pend_o = pend_c;
      end
   endgenerate
endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb #(
   parameter int NUM_REQ   = 4,
   parameter int OE_GROUPS = 4,
   parameter bit PEND_REG  = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   input  logic                 hold_req_i,
   input  logic                 boff_n_i,
   input  logic                 lock_i,
   input  logic                 cyc_busy_i,
   input  logic                 rdy_n_i,
   input  logic                 brdy_n_i,
   input  logic [NUM_REQ-1:0]   need_i,
   output logic [OE_GROUPS-1:0] bus_oe_o,
   output logic                 hold_ack_o,
   output logic                 restart_o,
   output logic                 rdy_ok_o,
   output logic                 brdy_ok_o,
   output logic                 pend_req_o
);
   import bha_pkg::*;

   localparam int OE_MSB = OE_GROUPS - 1;

   generate
      if (NUM_REQ < 1)   begin : g_bad_req $error("NUM_REQ must be at least 1"); end
      if (OE_GROUPS < 1) begin : g_bad_oe  $error("OE_GROUPS must be at least 1"); end
   endgenerate

   logic       ack;
   logic       boff_q;
   logic       intr_q;
   rel_cause_e cause;
   logic       drive;

   bha_hold_ctl u_hold (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .hold_req_i (hold_req_i),
      .cyc_busy_i (cyc_busy_i),
      .lock_i     (lock_i),
      .hold_ack_o (ack)
   );

   bha_boff_ctl u_boff (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .boff_n_i   (boff_n_i),
      .cyc_busy_i (cyc_busy_i),
      .boff_q_o   (boff_q),
      .intr_q_o   (intr_q),
      .restart_o  (restart_o)
   );

   bha_rdy_gate u_rdy (
      .boff_n_i  (boff_n_i),
      .rdy_n_i   (rdy_n_i),
      .brdy_n_i  (brdy_n_i),
      .rdy_ok_o  (rdy_ok_o),
      .brdy_ok_o (brdy_ok_o)
   );

   bha_pend #(.NUM_REQ(NUM_REQ), .PEND_REG(PEND_REG)) u_pend (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .need_i  (need_i),
      .intr_i  (intr_q),
      .pend_o  (pend_req_o)
   );

   assign cause = rel_cause(ack, boff_q);
   assign drive = drivers_on(cause);

   generate
      for (genvar g = 0; g <= OE_MSB; g++) begin : g_oe
         assign bus_oe_o[g] = drive;
      end
   endgenerate

   assign hold_ack_o = ack;
endmodule

// File: rtl/bha_chk.sv
module bha_chk #(
   parameter int NUM_REQ   = 4,
   parameter int OE_GROUPS = 4
) (
   input logic                 clk_i,
   input logic                 rst_n_i,
   input logic                 hold_req_i,
   input logic                 boff_n_i,
   input logic                 lock_i,
   input logic                 cyc_busy_i,
   input logic                 rdy_n_i,
   input logic                 brdy_n_i,
   input logic [NUM_REQ-1:0]   need_i,
   input logic [OE_GROUPS-1:0] bus_oe_o,
   input logic                 hold_ack_o,
   input logic                 restart_o,
   input logic                 rdy_ok_o,
   input logic                 brdy_ok_o,
   input logic                 pend_req_o
);
   p_busy_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!hold_ack_o && cyc_busy_i) |=> !hold_ack_o);

   p_no_lock_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!hold_ack_o && lock_i) |=> !hold_ack_o);

   p_ack_floats_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      hold_ack_o |-> (bus_oe_o == '0));

   p_boff_float_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !boff_n_i |=> (bus_oe_o == '0));

   p_rdy_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !boff_n_i |-> (!rdy_ok_o && !brdy_ok_o));

   p_one_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(rdy_ok_o && brdy_ok_o));

   p_restart_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      restart_o |=> !restart_o);

   p_restart_after_release_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      restart_o |-> $past(boff_n_i));

   p_ack_needs_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !hold_req_i |=> !hold_ack_o);

   p_pend_need_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (|need_i) |-> pend_req_o);
endmodule

bind bus_release_arb bha_chk #(.NUM_REQ(NUM_REQ), .OE_GROUPS(OE_GROUPS)) u_chk (
   .clk_i      (clk_i),
   .rst_n_i    (rst_n_i),
   .hold_req_i (hold_req_i),
   .boff_n_i   (boff_n_i),
   .lock_i     (lock_i),
   .cyc_busy_i (cyc_busy_i),
   .rdy_n_i    (rdy_n_i),
   .brdy_n_i   (brdy_n_i),
   .need_i     (need_i),
   .bus_oe_o   (bus_oe_o),
   .hold_ack_o (hold_ack_o),
   .restart_o  (restart_o),
   .rdy_ok_o   (rdy_ok_o),
   .brdy_ok_o  (brdy_ok_o),
   .pend_req_o (pend_req_o)
);

// File: tb/sim_bus_release_arb.sv
`timescale 1ns/1ps
module sim_bus_release_arb;
   localparam int NREQ = 4;
   localparam int NOE  = 4;
   localparam int NV   = 28;

   // Row: {hold, boff_n, lock, busy, rdy_n, brdy_n,  ack, oe, restart, rdy_ok, brdy_ok, pend}
   localparam logic [11:0] VEC [NV] = '{
      12'b010011_010000, // 0  idle
      12'b010001_010100, // 1  R6 single ready accepted
      12'b010000_010100, // 2  R6 both readies: burst ready dropped
      12'b010010_010010, // 3  R6 burst ready alone
      12'b110111_010000, // 4  R2 hold waits on busy
      12'b110111_010000, // 5  R2 still busy
      12'b110011_100000, // 6  R2 R4 grant, floated
      12'b110011_100000, // 7  R4 held
      12'b010011_010000, // 8  R4 release
      12'b111011_010000, // 9  R3 lock blocks grant
      12'b111011_010000, // 10 R3 lock blocks grant
      12'b110011_100000, // 11 R3 grant after lock clears
      12'b010011_010000, // 12 R4 release
      12'b000101_000001, // 13 R5 R6 R10 backoff with ready, busy
      12'b000011_000001, // 14 R7 still floated
      12'b010011_011000, // 15 R7 R8 released, restart
      12'b010011_010000, // 16 R8 one-clock pulse
      12'b000011_000000, // 17 R5 backoff while idle
      12'b010011_010000, // 18 R8 no restart
      12'b100011_100000, // 19 R9 hold and backoff
      12'b000011_000000, // 20 R9 hold gone, backoff holds float
      12'b100011_100000, // 21 R9 hold again
      12'b110011_100000, // 22 R9 backoff gone, hold holds float
      12'b010011_010000, // 23 R9 both released
      12'b100111_000001, // 24 R9 busy: no ack, backoff interrupts
      12'b100011_100001, // 25 R9 ack under backoff
      12'b010011_011000, // 26 R8 R9 both released, restart
      12'b010011_010000  // 27 R8 pulse ends
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic            hold_req, boff_n, lock, busy, rdy_n, brdy_n;
   logic [NREQ-1:0] need;
   logic [NOE-1:0]  bus_oe;
   logic            hold_ack, restart, rdy_ok, brdy_ok, pend_req;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   bus_release_arb #(.NUM_REQ(NREQ), .OE_GROUPS(NOE)) u0 (
      .clk_i(clk), .rst_n_i(rst_n), .hold_req_i(hold_req), .boff_n_i(boff_n),
      .lock_i(lock), .cyc_busy_i(busy), .rdy_n_i(rdy_n), .brdy_n_i(brdy_n),
      .need_i(need), .bus_oe_o(bus_oe), .hold_ack_o(hold_ack),
      .restart_o(restart), .rdy_ok_o(rdy_ok), .brdy_ok_o(brdy_ok),
      .pend_req_o(pend_req)
   );

   function automatic string row_req(int i);
      case (i)
         1, 2, 3:            return "R6";
         4, 5, 6:            return "R2";
         7, 8, 12:           return "R4";
         9, 10, 11:          return "R3";
         13, 17:             return "R5";
         14:                 return "R7";
         15, 16, 18, 27:     return "R8";
         default:            return (i >= 19) ? "R9" : "R1";
      endcase
   endfunction

   task automatic check(string req, string what, logic [5:0] act, logic [5:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   function automatic logic [5:0] observe();
      logic oe_all;
      oe_all = &bus_oe;
      if (bus_oe != '0 && !oe_all) oe_all = 1'bx;
      return {hold_ack, oe_all, restart, rdy_ok, brdy_ok, pend_req};
   endfunction

   task automatic drive(logic [5:0] v);
      {hold_req, boff_n, lock, busy, rdy_n, brdy_n} = v;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      rst_n = 1'b0;
      need  = '0;
      drive(6'b010011);
      repeat (3) @(negedge clk);
      check("R1", "reset state", observe(), 6'b010000);
      rst_n = 1'b1;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][11:6]);
         @(negedge clk);
         check(row_req(i), $sformatf("row %0d", i), observe(), VEC[i][5:0]);
      end

      // R10: need lines drive pending even while the bus is handed over
      drive(6'b110011);
      @(negedge clk);
      need = 4'b0100;
      #1;
      check("R10", "pend while acked", observe(), 6'b100001);
      need = 4'b0001;
      drive(6'b010011);
      @(negedge clk);
      check("R10", "pend while owned", observe(), 6'b010001);
      need = '0;
      #1;
      check("R10", "pend cleared", observe(), 6'b010000);

      // R1: reset during hold and backoff clears everything at once
      drive(6'b100111);
      @(negedge clk);
      drive(6'b100011);
      @(negedge clk);
      check("R9", "ack during backoff", observe(), 6'b100001);
      #1 rst_n = 1'b0;
      #1;
      check("R1", "async reset", observe(), 6'b010000);
      drive(6'b010011);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", "no restart after reset", observe(), 6'b010000);

      summary();
   end
endmodule